// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. The integrator, the zero comparator and the analog switches sit outside it. When asked to convert, it routes the unknown input into the integrator for a fixed number of clocks (run-up). It then switches a reference of opposite polarity onto the integrator (run-down) and counts clocks until the comparator shows that the integrator has crossed back through ground. Last, it grounds the integrator input for a fixed settle time (settle) before it accepts another request.

The count at the zero crossing is the conversion result. It equals the run-up length times the ratio of input to reference. The comparator is asynchronous to the block. It passes through a chain of synchronizer flops, and the run-down count is corrected by that chain's latency. The result is the number of reference clocks the integrator really needed. The sign of the input is taken from the comparator at the end of run-up, and that sign also picks which reference is applied.

The result, the sign and the overrange flag are plain held levels, not a stream. A one-cycle `done` strobe marks a new value. There is no back-pressure: the analog timing sets the pace of conversions, and a value stays valid until the next run-down ends.

Top module: `dsadc_ctrl`

## Requirements
- R1: A synchronous reset puts the sequencer in idle. After reset, `sw_sel` is 00 (ground), `done` is low, `result_mag` is zero, and `result_neg` and `overrange` are low.
- R2: A `start` seen in idle switches `sw_sel` to 01 (input) on the next cycle, with the counter cleared. `sw_sel` stays at 01 for exactly RUNUP_CLKS cycles.
- R3: On the cycle after the last run-up cycle, `sw_sel` changes to a reference. If the synchronized comparator is high (integrator below ground) at that edge, the code is 10 (negative reference) and `result_neg` becomes 0. Otherwise the code is 11 (positive reference) and `result_neg` becomes 1.
- R4: During run-down the block counts one per clock while the synchronized comparator keeps its run-up level. It stops on the first clock where the comparator has changed. `cmp_below` passes through SYNC_STAGES flops. `result_mag` is the count minus SYNC_STAGES, floored at zero, so it equals the number of reference clocks the integrator took to cross ground.
- R5: When the corrected count would exceed full scale (2^MAG_W − 1) with no crossing, run-down ends, `overrange` goes to 1 and `result_mag` is all ones. A crossing that lands exactly on full scale gives full scale with `overrange` at 0.
- R6: After run-down, `sw_sel` is 00 for exactly SETTLE_CLKS cycles. `done` is then high for a single cycle as the block returns to idle.
- R7: `result_mag`, `result_neg` and `overrange` change only when a run-down ends. They are held through the settle phase and through the next run-up.
- R8: A `start` asserted while a conversion is under way has no effect: it neither restarts run-up nor launches a second conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, taken only in idle |
| cmp_below | input | 1 | Comparator output, high while the integrator is below ground (asynchronous) |
| sw_sel | output | 2 | Switch select: 00 ground, 01 input, 10 negative reference, 11 positive reference |
| result_mag | output | MAG_W | Converted magnitude |
| result_neg | output | 1 | Sign of the input, 1 for negative |
| overrange | output | 1 | Run-down hit full scale without a crossing |
| done | output | 1 | One-cycle strobe at the end of a conversion |

## Verification
The hardest states to reach from the ports are the two sides of the full-scale boundary: a crossing that lands exactly on full scale, and a run-down that runs past it. Both depend on the integrator charge accumulated over run-up. The bench's behavioural integrator is an integer model driven by `sw_sel`. The stimulus picks an input-to-reference ratio that places the crossing exactly at full scale, at one count beyond it, and at the same points for negative inputs. Ignored requests are checked by pulsing `start` in the middle of run-up and again during run-down. The bench then confirms that run-up length, the result and the idle state after `done` are unchanged.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    SW_GND  = 2'b00,
    SW_VIN  = 2'b01,
    SW_REFN = 2'b10,
    SW_REFP = 2'b11
  } sw_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RUNUP,
    PH_RUNDOWN,
    PH_SETTLE
  } phase_e;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic ff;
      always_ff @(posedge clk) begin
        if (rst) ff <= 1'b0;
        else     ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned RUNUP_CLKS  = 1000,
  parameter int unsigned SETTLE_CLKS = 200,
  parameter int unsigned RD_LIMIT    = 65537
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_s,
  output sw_sel_e          sel,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_end,
  output logic             rd_over,
  output logic             pol_neg,
  output logic             done
);

  localparam logic [CNT_W-1:0] RU_LAST = CNT_W'(RUNUP_CLKS - 1);
  localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(SETTLE_CLKS - 1);
  localparam logic [CNT_W-1:0] RD_TOP  = CNT_W'(RD_LIMIT);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             far;
  logic             at_top;

  // still on the side of ground the run-up drove the integrator to
  assign far    = (cmp_s == !pol_neg);
  assign at_top = (cnt == RD_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      pol_neg <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_RUNUP;
            cnt   <= '0;
          end
        end
        PH_RUNUP: begin
          if (cnt == RU_LAST) begin
            phase   <= PH_RUNDOWN;
            cnt     <= '0;
            pol_neg <= !cmp_s;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUNDOWN: begin
          if (far && !at_top) begin
            cnt <= cnt + 1'b1;
          end else begin
            phase <= PH_SETTLE;
            cnt   <= '0;
          end
        end
        PH_SETTLE: begin
          if (cnt == ST_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_RUNUP:   sel = SW_VIN;
      PH_RUNDOWN: sel = pol_neg ? SW_REFP : SW_REFN;
      default:    sel = SW_GND;
    endcase
  end

  assign rd_cnt  = cnt;
  assign rd_end  = (phase == PH_RUNDOWN) && (!far || at_top);
  assign rd_over = (phase == PH_RUNDOWN) && far && at_top;

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int unsigned MAG_W = 16,
  parameter int unsigned CNT_W = 18,
  parameter int unsigned LAT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_end,
  input  logic             rd_over,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic             pol_neg,
  output logic [MAG_W-1:0] mag,
  output logic             neg,
  output logic             over
);

  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  logic [CNT_W-1:0] corrected;

  // remove the comparator synchronizer delay, never below zero
  assign corrected = (rd_cnt < LAT_C) ? '0 : (rd_cnt - LAT_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      mag  <= '0;
      neg  <= 1'b0;
      over <= 1'b0;
    end else if (rd_end) begin
      neg  <= pol_neg;
      over <= rd_over;
      mag  <= rd_over ? '1 : corrected[MAG_W-1:0];
    end
  end

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned MAG_W       = 16,
  parameter int unsigned RUNUP_CLKS  = 1000,
  parameter int unsigned SETTLE_CLKS = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_below,
  output logic [1:0]       sw_sel,
  output logic [MAG_W-1:0] result_mag,
  output logic             result_neg,
  output logic             overrange,
  output logic             done
);

  localparam int unsigned FULL_SCALE = (1 << MAG_W) - 1;
  localparam int unsigned RD_LIMIT   = FULL_SCALE + SYNC_STAGES;
  localparam int unsigned TOP_A      = (RUNUP_CLKS > RD_LIMIT) ? RUNUP_CLKS : RD_LIMIT;
  localparam int unsigned CNT_TOP    = (TOP_A > SETTLE_CLKS) ? TOP_A : SETTLE_CLKS;
  localparam int unsigned CNT_W      = $clog2(CNT_TOP + 1);

  logic             cmp_s;
  sw_sel_e          sel;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_end;
  logic             rd_over;
  logic             pol_neg;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_below),
    .q   (cmp_s)
  );

  dsadc_seq #(
    .CNT_W       (CNT_W),
    .RUNUP_CLKS  (RUNUP_CLKS),
    .SETTLE_CLKS (SETTLE_CLKS),
    .RD_LIMIT    (RD_LIMIT)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cmp_s   (cmp_s),
    .sel     (sel),
    .rd_cnt  (rd_cnt),
    .rd_end  (rd_end),
    .rd_over (rd_over),
    .pol_neg (pol_neg),
    .done    (done)
  );

  dsadc_result #(
    .MAG_W (MAG_W),
    .CNT_W (CNT_W),
    .LAT   (SYNC_STAGES)
  ) u_res (
    .clk     (clk),
    .rst     (rst),
    .rd_end  (rd_end),
    .rd_over (rd_over),
    .rd_cnt  (rd_cnt),
    .pol_neg (pol_neg),
    .mag     (result_mag),
    .neg     (result_neg),
    .over    (overrange)
  );

  assign sw_sel = sel;

endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk
  import dsadc_pkg::*;
#(
  parameter int unsigned MAG_W      = 16,
  parameter int unsigned RUNUP_CLKS = 1000
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       sw_sel,
  input logic [MAG_W-1:0] result_mag,
  input logic             result_neg,
  input logic             overrange,
  input logic             done
);

  int unsigned vin_run;

  always_ff @(posedge clk) begin
    if (rst)                  vin_run <= 0;
    else if (sw_sel == SW_VIN) vin_run <= vin_run + 1;
    else                      vin_run <= 0;
  end

  // R2 / R8: run-up is never cut short nor stretched by a further start
  assert_runup_len_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_sel) == SW_VIN && sw_sel != SW_VIN) |-> vin_run == RUNUP_CLKS);

  assert_runup_exit_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_sel) == SW_VIN && sw_sel != SW_VIN) |-> (sw_sel == SW_REFN || sw_sel == SW_REFP));

  assert_overrange_full_R5: assert property (@(posedge clk) disable iff (rst)
    overrange |-> result_mag == '1);

  assert_done_ground_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> sw_sel == SW_GND);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_runup_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_sel == SW_VIN) |-> ($stable(result_mag) && $stable(result_neg) && $stable(overrange)));

endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(
  .MAG_W      (MAG_W),
  .RUNUP_CLKS (RUNUP_CLKS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sw_sel     (sw_sel),
  .result_mag (result_mag),
  .result_neg (result_neg),
  .overrange  (overrange),
  .done       (done)
);

// File: tb/dsadc_ctrl_test.sv
`timescale 1ns/1ps
module dsadc_ctrl_test;

  localparam int MAG_W  = 8;
  localparam int N1     = 64;
  localparam int NZ     = 4;
  localparam int SYNC   = 2;
  localparam int FULL   = (1 << MAG_W) - 1;
  localparam int NV     = 12;
  // {input, reference} in integrator units per clock
  localparam int VECS [NV][2] = '{
    '{3, 64}, '{1, 7}, '{-3, 64}, '{-5, 7}, '{255, 64}, '{256, 64},
    '{-254, 64}, '{-255, 64}, '{0, 64}, '{100, 32}, '{-1, 100}, '{7, 5}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             cmp_below;
  logic [1:0]       sw_sel;
  logic [MAG_W-1:0] result_mag;
  logic             result_neg;
  logic             overrange;
  logic             done;

  int vin  = 0;
  int vref = 64;
  int vint = 0;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  dsadc_ctrl #(
    .MAG_W       (MAG_W),
    .RUNUP_CLKS  (N1),
    .SETTLE_CLKS (NZ),
    .SYNC_STAGES (SYNC)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmp_below  (cmp_below),
    .sw_sel     (sw_sel),
    .result_mag (result_mag),
    .result_neg (result_neg),
    .overrange  (overrange),
    .done       (done)
  );

  // behavioural inverting integrator
  always @(posedge clk) begin
    if (rst) vint <= 0;
    else case (sw_sel)
      2'b01:   vint <= vint - vin;
      2'b10:   vint <= vint + vref;
      2'b11:   vint <= vint - vref;
      default: vint <= 0;
    endcase
  end
  assign cmp_below = (vint < 0);

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference clocks needed to cross ground, from the integrator model
  task automatic expect_of(input int vi, input int vr, output int mag, output int neg, output int ovr);
    int charge = N1 * vi;
    int k;
    if (vi > 0) begin
      k = (charge + vr - 1) / vr;
      neg = 0;
    end else begin
      k = (-charge) / vr + 1;
      neg = 1;
    end
    ovr = (k > FULL) ? 1 : 0;
    mag = ovr ? FULL : k;
  endtask

  task automatic convert(input int vi, input int vr, input bit poke,
                         output int ru, output int refn, output int refp,
                         output int st, output int got, output int held);
    bit seen_ref = 0;
    ru = 0; refn = 0; refp = 0; st = 0; got = 0; held = -1;
    @(negedge clk);
    vin = vi; vref = vr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      start = 1'b0;
      if (done) begin
        got = 1;
        break;
      end
      case (sw_sel)
        2'b01: begin
          ru++;
          if (poke && ru == 20) begin
            start = 1'b1;
            held = int'(result_mag);
          end
        end
        2'b10: begin refn++; seen_ref = 1; if (poke && refn == 1) start = 1'b1; end
        2'b11: begin refp++; seen_ref = 1; if (poke && refp == 1) start = 1'b1; end
        default: if (seen_ref) st++;
      endcase
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic main_seq();
    int ru, refn, refp, st, got, held, em, en, eo;
    int prev_mag;
    repeat (3) @(negedge clk);
    check("R1 sel after reset", int'(sw_sel), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 result after reset", int'(result_mag), 0);
    check("R1 sign/overrange after reset", int'({result_neg, overrange}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      expect_of(VECS[v][0], VECS[v][1], em, en, eo);
      convert(VECS[v][0], VECS[v][1], 1'b0, ru, refn, refp, st, got, held);
      check("R6 done reached", got, 1);
      check("R4 magnitude", int'(result_mag), em);
      check("R3 sign", int'(result_neg), en);
      check("R5 overrange", int'(overrange), eo);
      check("R2 run-up length", ru, N1);
      check("R6 settle length", st, NZ);
      check("R3 reference choice", (en ? refn : refp), 0);
      @(negedge clk);
      check("R6 done one cycle", int'(done), 0);
    end

    // R7 and R8: extra starts during run-up and run-down
    prev_mag = int'(result_mag);
    expect_of(10, 64, em, en, eo);
    convert(10, 64, 1'b1, ru, refn, refp, st, got, held);
    check("R7 result held in run-up", held, prev_mag);
    check("R8 run-up not restarted", ru, N1);
    check("R8 result unaffected", int'(result_mag), em);
    for (int i = 0; i < 10; i++) @(negedge clk);
    check("R8 no second conversion", int'(sw_sel), 0);
    check("R7 result held after done", int'(result_mag), em);

    // R1: reset in the middle of run-down
    @(negedge clk);
    vin = 50; vref = 10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N1 + 5) @(negedge clk);
    check("R3 in run-down before reset", int'(sw_sel), 2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 sel after mid reset", int'(sw_sel), 0);
    check("R1 result after mid reset", int'(result_mag), 0);
    got = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (done || sw_sel != 2'b00) got = 1;
    end
    check("R1 idle after mid reset", got, 0);

    expect_of(-9, 13, em, en, eo);
    convert(-9, 13, 1'b0, ru, refn, refp, st, got, held);
    check("R4 magnitude after reset", int'(result_mag), em);
    check("R3 sign after reset", int'(result_neg), en);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule